// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block collects the three event sources of a real-time clock: the periodic tick, the alarm match and the end of an update cycle. Each source arrives as a single-cycle pulse. The block holds each pulse as a sticky flag in a status register. A flag is recorded whether or not its source is enabled. A flag whose matching enable bit is set raises an interrupt request. Every request also sets a summary bit in the status register.

The interrupt output behaves like an open-drain, active-low line. It is modelled as a drive-enable that is high while any enabled flag is set, together with a data value that is always zero. The host either services that line or leaves every enable clear and polls the status register. In both cases, a strobe marking a read of the status register clears all flags and the summary bit, and this releases the line.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: An event pulse on source i sets its status flag on the next clock edge, even when enable bit i is clear. Source 0 (periodic) maps to status bit 6, source 1 (alarm) to bit 5 and source 2 (update-ended) to bit 4.
- R2: A flag that has been set stays set on every later cycle until a status read strobe is taken.
- R3: A read strobe clears every source flag and the summary bit (status bit 7) on the clock edge that takes the strobe.
- R4: An event that arrives in the same cycle as a read strobe is kept. After that edge its flag reads set, and the summary bit is set again if that source is enabled.
- R5: The interrupt drive-enable is high exactly while at least one set flag has its enable bit set. It drops as soon as the flags are cleared or the enables are removed.
- R6: The summary bit sets on the same edge as a flag whose source is already enabled. If a source is enabled while its flag is already set, the drive-enable rises in that same cycle and the summary bit sets on the next edge.
- R7: Once set, the summary bit stays set until a read strobe, even if the enable that caused it is cleared.
- R8: With all enables clear, events set their flags but the drive-enable never rises.
- R9: Status bits 3 to 0 always read zero, and the interrupt data output is always zero.
- R10: During and right after reset, the status register is zero and the drive-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Single-cycle event pulses: bit 0 periodic, bit 1 alarm, bit 2 update-ended |
| en_i | input | NUM_SRC | Interrupt enable for each source, same order as evt_i |
| rd_stb_i | input | 1 | High for one cycle when the host reads the status register |
| status_o | output | STATUS_W | Status register: bit 7 summary, bits 6..4 source flags, bits 3..0 zero |
| irq_oe_o | output | 1 | Drive-enable of the interrupt line (high = pull low) |
| irq_data_o | output | 1 | Value driven on the interrupt line, always 0 |

## Verification
The bench builds the block with its default parameters: three sources and an eight-bit status register. This gives every source flag its own status bit and leaves the four zero bits visible. With these values, the bench reaches the collision of an event with a clearing read and a late enable on a flag that is already set. It also reaches a summary bit that outlives its enable, and all three sources firing together.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  localparam int unsigned SRC_CNT = 3;
  localparam int unsigned STAT_W  = 8;

  typedef enum logic [1:0] {
    SRC_PERIODIC = 2'd0,
    SRC_ALARM    = 2'd1,
    SRC_UPDATE   = 2'd2
  } src_e;

  // Status bit that holds the flag of source idx: the flags sit just
  // below the summary bit, with source 0 in the highest position.
  function automatic int unsigned flag_pos(int unsigned stat_w, int unsigned idx);
    return stat_w - 2 - idx;
  endfunction

  // Next value of a sticky flag: cleared by a read, but a new event wins.
  function automatic logic sticky_next(logic cur, logic clr, logic set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_q_o,
  output logic [N-1:0] flag_d_o
);
  import rtc_irq_pkg::*;

  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    logic q;
    assign flag_d_o[gi] = sticky_next(q, clr_i, evt_i[gi]);
    always_ff @(posedge clk_i) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= flag_d_o[gi];
    end
    assign flag_q_o[gi] = q;
  end

endmodule

// File: rtl/rtc_irq_summary.sv
module rtc_irq_summary #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_q_i,
  input  logic [N-1:0] flag_d_i,
  input  logic [N-1:0] en_i,
  input  logic         clr_i,
  output logic         intf_q_o,
  output logic         req_next_o,
  output logic         irq_oe_o
);
  import rtc_irq_pkg::*;

  logic intf_q;

  // A request exists on the next edge when any next-state flag is enabled.
  assign req_next_o = |(flag_d_i & en_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) intf_q <= 1'b0;
    else         intf_q <= sticky_next(intf_q, clr_i, req_next_o);
  end

  assign intf_q_o = intf_q;
  // The line is pulled low while any current flag is enabled.
  assign irq_oe_o = |(flag_q_i & en_i);

endmodule

// File: rtl/rtc_irq_status_pack.sv
module rtc_irq_status_pack #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0] flag_q_i,
  input  logic         intf_q_i,
  output logic [W-1:0] status_o
);
  import rtc_irq_pkg::*;

  localparam int unsigned LOW_W = W - 1 - N;

  assign status_o[W-1] = intf_q_i;
  for (genvar gi = 0; gi < N; gi++) begin : g_pos
    assign status_o[flag_pos(W, gi)] = flag_q_i[gi];
  end
  if (LOW_W > 0) begin : g_zero
    assign status_o[LOW_W-1:0] = '0;
  end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned NUM_SRC  = rtc_irq_pkg::SRC_CNT,
  parameter int unsigned STATUS_W = rtc_irq_pkg::STAT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  evt_i,
  input  logic [NUM_SRC-1:0]  en_i,
  input  logic                rd_stb_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                irq_oe_o,
  output logic                irq_data_o
);

  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_d;
  logic               intf_q;
  logic               req_next;

  rtc_irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .clr_i    (rd_stb_i),
    .flag_q_o (flag_q),
    .flag_d_o (flag_d)
  );

  rtc_irq_summary #(.N(NUM_SRC)) u_summary (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag_q_i   (flag_q),
    .flag_d_i   (flag_d),
    .en_i       (en_i),
    .clr_i      (rd_stb_i),
    .intf_q_o   (intf_q),
    .req_next_o (req_next),
    .irq_oe_o   (irq_oe_o)
  );

  rtc_irq_status_pack #(.N(NUM_SRC), .W(STATUS_W)) u_pack (
    .flag_q_i (flag_q),
    .intf_q_i (intf_q),
    .status_o (status_o)
  );

  assign irq_data_o = 1'b0;

endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC  = 3,
  parameter int unsigned STATUS_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_SRC-1:0]  evt_i,
  input logic [NUM_SRC-1:0]  en_i,
  input logic                rd_stb_i,
  input logic [STATUS_W-1:0] status_o,
  input logic                irq_oe_o,
  input logic                irq_data_o
);
  localparam int unsigned LOW_W = STATUS_W - 1 - NUM_SRC;

  logic [NUM_SRC-1:0] flags;
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_f
    assign flags[gi] = status_o[STATUS_W-2-gi];
  end

  // R1
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i)));

  // R2
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> ((flags & $past(flags)) == $past(flags)));

  // R3
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && evt_i == '0) |=> (status_o == '0));

  // R7
  intf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[STATUS_W-1] && !rd_stb_i) |=> status_o[STATUS_W-1]);

  // R6
  oe_sets_intf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_oe_o && !rd_stb_i) |=> status_o[STATUS_W-1]);

  // R8
  no_enable_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !irq_oe_o);

  // R9
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[LOW_W-1:0] == '0) && !irq_data_o);

endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .STATUS_W(STATUS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .en_i       (en_i),
  .rd_stb_i   (rd_stb_i),
  .status_o   (status_o),
  .irq_oe_o   (irq_oe_o),
  .irq_data_o (irq_data_o)
);

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt = '0;
  logic [2:0] en = '0;
  logic       rd = 1'b0;
  logic [7:0] status;
  logic       oe;
  logic       data;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .en_i(en), .rd_stb_i(rd),
    .status_o(status), .irq_oe_o(oe), .irq_data_o(data)
  );

  // Expected status bit of source i, restated from R1.
  function automatic logic [7:0] src_mask(int i);
    return 8'h40 >> i;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Inputs change on the falling edge; results are read on the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] e);
    evt = e; step(); evt = '0;
  endtask

  task automatic host_read();
    rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic t_reset();
    chk(status, 8'h00, "R10 status in reset");
    chk({7'd0, oe}, 8'h00, "R10 oe in reset");
    rst_n = 1'b1; step();
    chk(status, 8'h00, "R10 status after reset");
    chk({7'd0, data}, 8'h00, "R9 data low");
  endtask

  task automatic t_polling();
    en = '0;
    for (int i = 0; i < 3; i++) begin
      pulse(3'b001 << i);
      chk(status, src_mask(i), "R1 flag without enable");
      chk({7'd0, oe}, 8'h00, "R8 no drive when disabled");
      host_read();
      chk(status, 8'h00, "R3 read clears");
    end
  endtask

  task automatic t_hold();
    pulse(3'b010);
    for (int k = 0; k < 5; k++) step();
    chk(status, 8'h20, "R2 flag holds");
    host_read();
    chk(status, 8'h00, "R3 cleared after hold");
  endtask

  task automatic t_enabled();
    en = 3'b010;
    pulse(3'b010);
    chk(status, 8'hA0, "R6 summary with flag");
    chk({7'd0, oe}, 8'h01, "R5 drive on enabled flag");
    host_read();
    chk(status, 8'h00, "R3 clears summary");
    chk({7'd0, oe}, 8'h00, "R5 release after read");
    en = '0;
  endtask

  task automatic t_late_enable();
    pulse(3'b001);
    chk(status, 8'h40, "R1 periodic flag");
    en = 3'b001; #1;
    chk({7'd0, oe}, 8'h01, "R6 drive at enable");
    chk(status, 8'h40, "R6 summary not yet");
    step();
    chk(status, 8'hC0, "R6 summary one edge later");
    host_read();
    en = '0;
  endtask

  task automatic t_sticky_intf();
    en = 3'b100;
    pulse(3'b100);
    chk(status, 8'h90, "R6 update request");
    en = '0; #1;
    chk({7'd0, oe}, 8'h00, "R5 drop with enable");
    step();
    chk(status, 8'h90, "R7 summary stays");
    host_read();
    chk(status, 8'h00, "R3 read clears summary");
  endtask

  task automatic t_collide();
    pulse(3'b001);
    rd = 1'b1; evt = 3'b010; step(); rd = 1'b0; evt = '0;
    chk(status, 8'h20, "R4 event with read kept");
    host_read();
    en = 3'b010;
    pulse(3'b001);
    rd = 1'b1; evt = 3'b010; step(); rd = 1'b0; evt = '0;
    chk(status, 8'hA0, "R4 enabled event with read");
    chk({7'd0, oe}, 8'h01, "R4 drive kept");
    host_read(); en = '0;
  endtask

  task automatic t_all();
    en = 3'b111;
    pulse(3'b111);
    chk(status, 8'hF0, "R1 all sources");
    chk(status & 8'h0F, 8'h00, "R9 low bits zero");
    chk({7'd0, data}, 8'h00, "R9 data low");
    host_read();
    chk({7'd0, oe}, 8'h00, "R5 released");
    en = '0;
  endtask

  bit finished = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_polling();
    t_hold();
    t_enabled();
    t_late_enable();
    t_sticky_intf();
    t_collide();
    t_all();
    finished = 1;
    summary();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule